// File: doc/BRIEF.md
# Serial Control Word Latch for an Audio Attenuator

This block receives control words for a stereo volume, fader and tone path over a three-wire serial link: an enable line, a data line and a bit clock. The three lines are oversampled by a much faster system clock. While the enable line is high, each rising bit-clock edge shifts one data bit, most significant first, into a shadow register. The falling edge of the enable line commits the shadow contents to an active latch. The latch outputs feed the downstream attenuator and tone switch decoders. A one-cycle strobe tells those decoders that new settings are present.

A transfer whose bit count is not exactly one word long is dropped, and the latch keeps its old value. A separate active-low initialisation input puts the latch into a safe state at once, without waiting for a clock edge. In that state the fader sits at full attenuation (mute). While initialisation is held low, serial writes are ignored. Its release is resynchronised to the system clock.

Top module: `svl_serial_latch`

## Requirements
- R1: While `init_n` is low, the outputs show the safe state, and they show it at once, with no clock edge needed. The safe state is: both volume fields 0, `fade_lvl_o` = 15 (mute), `fade_rear_o` = 0, `bass_o` = 7, `treble_o` = 7, `upd_o` = 0.
- R2: The outputs change only after a high-to-low transition of `ser_ce`. They stay unchanged while bits are being shifted in.
- R3: Bits are taken from `ser_di` at rising edges of `ser_clk` while `ser_ce` is high, most significant bit first. The 27-bit word is laid out as follows: [26:20] left volume, [19:13] right volume, [12:9] fader level, [8] fader rear select, [7:4] bass, [3:0] treble.
- R4: A transfer of fewer or more than 27 bits leaves every output unchanged. This includes a transfer with zero bits.
- R5: `upd_o` pulses high for exactly one system clock for each accepted transfer, in the same cycle the new settings appear. It stays low for rejected transfers.
- R6: While `init_n` is low, serial transfers have no effect. After `init_n` rises, the safe state is kept until the next accepted transfer, and transfers are then accepted normally.
- R7: `ser_clk` and `ser_di` activity while `ser_ce` is low changes no output and produces no strobe.
- R8: After `ser_ce` returns high, a new transfer can begin. Back-to-back transfers each commit their own word and each give one strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset for the synchronisers and the shifter |
| init_n | input | 1 | Asynchronous active-low initialisation; forces the safe muted state |
| ser_ce | input | 1 | Serial enable; its falling edge commits the word |
| ser_clk | input | 1 | Serial bit clock |
| ser_di | input | 1 | Serial data, most significant bit first |
| vol_l_o | output | 7 | Left channel volume code |
| vol_r_o | output | 7 | Right channel volume code |
| fade_lvl_o | output | 4 | Fader attenuation code, 15 = mute |
| fade_rear_o | output | 1 | Fader acts on the rear outputs when 1, on the front when 0 |
| bass_o | output | 4 | Bass tone code |
| treble_o | output | 4 | Treble tone code |
| upd_o | output | 1 | One-cycle strobe marking new settings |

## Verification
The assertions assume that every serial line is held steady for many system clocks around each of its edges. They also assume that an enable edge never lands in the same synchronised cycle as a bit-clock rising edge, so that each bit sampled from the synchronised data line is the settled one. The stimulus holds every phase of the serial lines for eight system clocks. That is well above the two-flop synchroniser delay. Data is changed while the bit clock is low, and the enable line moves only a full phase away from any bit-clock edge. Initialisation is driven between clock edges, so the asynchronous path can be observed with no edge in between.

// File: rtl/svl_pkg.sv
package svl_pkg;
  localparam int VOL_W  = 7;
  localparam int FADE_W = 4;
  localparam int TONE_W = 4;
  localparam int WORD_W = 2 * VOL_W + FADE_W + 1 + 2 * TONE_W;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [VOL_W-1:0]  vol_l;
    logic [VOL_W-1:0]  vol_r;
    logic [FADE_W-1:0] fade_lvl;
    logic              fade_rear;
    logic [TONE_W-1:0] bass;
    logic [TONE_W-1:0] treble;
  } ctl_word_t;

  localparam ctl_word_t CTL_SAFE = '{
    vol_l:     '0,
    vol_r:     '0,
    fade_lvl:  '1,
    fade_rear: 1'b0,
    bass:      TONE_W'(7),
    treble:    TONE_W'(7)
  };
endpackage

// File: rtl/svl_sync.sv
module svl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/svl_init_sync.sv
module svl_init_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic init_n,
  output logic init_ok
);
  logic [STAGES-1:0] rel;

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) rel <= '0;
    else         rel <= {rel[STAGES-2:0], 1'b1};
  end

  assign init_ok = rel[STAGES-1];
endmodule

// File: rtl/svl_shifter.sv
module svl_shifter
  import svl_pkg::*;
#(
  parameter int N = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_ok,
  input  logic         ce_s,
  input  logic         sck_s,
  input  logic         di_s,
  output logic         commit_o,
  output logic [N-1:0] word_o
);
  localparam int CNT_W = $clog2(N + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(N + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N);

  logic             ce_d, sck_d, commit_q, commit_n;
  logic [N-1:0]     sh_q, sh_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             sck_rise, ce_rise, ce_fall;

  assign sck_rise = sck_s & ~sck_d;
  assign ce_rise  = ce_s & ~ce_d;
  assign ce_fall  = ~ce_s & ce_d;

  always_comb begin
    sh_n     = sh_q;
    cnt_n    = cnt_q;
    commit_n = 1'b0;
    if (ce_rise) begin
      cnt_n = '0;
    end else if (ce_s && sck_rise) begin
      sh_n = {sh_q[N-2:0], di_s};
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end else if (ce_fall) begin
      commit_n = init_ok && (cnt_q == CNT_FULL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d     <= 1'b0;
      sck_d    <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      ce_d     <= ce_s;
      sck_d    <= sck_s;
      sh_q     <= sh_n;
      cnt_q    <= cnt_n;
      commit_q <= commit_n;
    end
  end

  assign commit_o = commit_q;
  assign word_o   = sh_q;

  p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_commit_ce_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> !ce_d);
  p_no_commit_in_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !init_ok |=> !commit_q);
endmodule

// File: rtl/svl_latch.sv
module svl_latch
  import svl_pkg::*;
(
  input  logic              clk,
  input  logic              init_ok,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output ctl_word_t         ctl_o,
  output logic              upd_o
);
  ctl_word_t ctl_q, ctl_n;
  logic      upd_q;

  always_comb begin
    ctl_n = ctl_q;
    if (commit_i) ctl_n = ctl_word_t'(word_i);
  end

  always_ff @(posedge clk or negedge init_ok) begin
    if (!init_ok) begin
      ctl_q <= CTL_SAFE;
      upd_q <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      upd_q <= commit_i;
    end
  end

  assign ctl_o = ctl_q;
  assign upd_o = upd_q;

  p_change_flagged_r5: assert property (@(posedge clk) disable iff (!init_ok)
    (ctl_q != $past(ctl_q)) |-> upd_q);
  p_upd_single_r5: assert property (@(posedge clk) disable iff (!init_ok)
    upd_q |=> !upd_q);
endmodule

// File: rtl/svl_serial_latch.sv
module svl_serial_latch
  import svl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_n,
  input  logic              ser_ce,
  input  logic              ser_clk,
  input  logic              ser_di,
  output logic [VOL_W-1:0]  vol_l_o,
  output logic [VOL_W-1:0]  vol_r_o,
  output logic [FADE_W-1:0] fade_lvl_o,
  output logic              fade_rear_o,
  output logic [TONE_W-1:0] bass_o,
  output logic [TONE_W-1:0] treble_o,
  output logic              upd_o
);
  logic [2:0]        ln_s;
  logic              init_ok, commit;
  logic [WORD_W-1:0] word;
  ctl_word_t         ctl;

  svl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_ce, ser_clk, ser_di}), .q(ln_s));

  svl_init_sync #(.STAGES(SYNC_STAGES)) u_init (
    .clk(clk), .init_n(init_n), .init_ok(init_ok));

  svl_shifter #(.N(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .init_ok(init_ok),
    .ce_s(ln_s[2]), .sck_s(ln_s[1]), .di_s(ln_s[0]),
    .commit_o(commit), .word_o(word));

  svl_latch u_latch (
    .clk(clk), .init_ok(init_ok), .commit_i(commit), .word_i(word),
    .ctl_o(ctl), .upd_o(upd_o));

  assign vol_l_o     = ctl.vol_l;
  assign vol_r_o     = ctl.vol_r;
  assign fade_lvl_o  = ctl.fade_lvl;
  assign fade_rear_o = ctl.fade_rear;
  assign bass_o      = ctl.bass;
  assign treble_o    = ctl.treble;
endmodule

// File: tb/tb_svl_serial_latch.sv
`timescale 1ns/1ps
module tb_svl_serial_latch;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, init_n, ser_ce, ser_clk, ser_di, upd_o, fade_rear_o;
  logic [6:0] vol_l_o, vol_r_o;
  logic [3:0] fade_lvl_o, bass_o, treble_o;

  svl_serial_latch dut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .ser_ce(ser_ce),
    .ser_clk(ser_clk), .ser_di(ser_di), .vol_l_o(vol_l_o), .vol_r_o(vol_r_o),
    .fade_lvl_o(fade_lvl_o), .fade_rear_o(fade_rear_o), .bass_o(bass_o),
    .treble_o(treble_o), .upd_o(upd_o));

  localparam logic [26:0] SAFE = {7'd0, 7'd0, 4'd15, 1'b0, 4'd7, 4'd7};
  // {bit count, word}
  localparam logic [32:0] VEC [0:7] = '{
    {6'd27, 27'h1234567}, {6'd27, 27'h5A5A5A5}, {6'd26, 27'h3C3C3C3},
    {6'd28, 27'h0F0F0F0}, {6'd0,  27'h7FFFFFF}, {6'd27, 27'h7FFFFFF},
    {6'd1,  27'h6DB6DB6}, {6'd27, 27'h0000000}};

  int checks = 0, fails = 0, upd_cnt = 0;
  logic [26:0] got, exp_w;
  assign got = {vol_l_o, vol_r_o, fade_lvl_o, fade_rear_o, bass_o, treble_o};

  always @(negedge clk) if (upd_o === 1'b1) upd_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic phase();
    repeat (8) @(negedge clk);
  endtask

  task automatic send(int n, logic [26:0] w);
    ser_ce = 1'b1; phase();
    for (int i = 0; i < n; i++) begin
      ser_di = (i < 27) ? w[26-i] : 1'b0; phase();
      ser_clk = 1'b1; phase();
      ser_clk = 1'b0;
    end
    phase();
    ser_ce = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int u0;
    rst_n = 1'b0; init_n = 1'b0; ser_ce = 1'b0; ser_clk = 1'b0; ser_di = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 safe state", 32'(got), 32'(SAFE));
    chk("R1 no strobe", 32'(upd_o), 0);
    rst_n = 1'b1; init_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 safe kept after release", 32'(got), 32'(SAFE));

    exp_w = SAFE;
    for (int k = 0; k < 8; k++) begin
      int n;
      n = int'(VEC[k][32:27]);
      u0 = upd_cnt;
      send(n, VEC[k][26:0]);
      if (n == 27) begin
        exp_w = VEC[k][26:0];
        chk("R3 word committed", 32'(got), 32'(exp_w));
        chk("R5 one strobe", upd_cnt - u0, 1);
      end else begin
        chk("R4 wrong length dropped", 32'(got), 32'(exp_w));
        chk("R5 no strobe on reject", upd_cnt - u0, 0);
      end
    end

    // R2: no change while shifting a full word
    u0 = upd_cnt;
    ser_ce = 1'b1; phase();
    for (int i = 0; i < 27; i++) begin
      ser_di = 27'h2468ACE >> (26 - i); phase();
      ser_clk = 1'b1; phase(); ser_clk = 1'b0;
    end
    phase();
    chk("R2 held before ce fall", 32'(got), 32'(exp_w));
    chk("R2 no strobe before ce fall", upd_cnt - u0, 0);
    ser_ce = 1'b0; repeat (20) @(negedge clk);
    exp_w = 27'h2468ACE;
    chk("R2 committed on ce fall", 32'(got), 32'(exp_w));

    // R7: clock activity with enable low
    u0 = upd_cnt;
    for (int i = 0; i < 30; i++) begin
      ser_di = i[0]; phase(); ser_clk = 1'b1; phase(); ser_clk = 1'b0;
    end
    repeat (20) @(negedge clk);
    chk("R7 outputs unchanged", 32'(got), 32'(exp_w));
    chk("R7 no strobe", upd_cnt - u0, 0);

    // R8: back-to-back transfers
    u0 = upd_cnt;
    send(27, 27'h1B2C3D4);
    send(27, 27'h0A1B2C3);
    exp_w = 27'h0A1B2C3;
    chk("R8 second word", 32'(got), 32'(exp_w));
    chk("R8 two strobes", upd_cnt - u0, 2);

    // R1: asynchronous init, checked before any clock edge
    @(negedge clk); #0.5 init_n = 1'b0; #1;
    chk("R1 async mute", 32'(fade_lvl_o), 15);
    chk("R1 async safe", 32'(got), 32'(SAFE));

    // R6: writes ignored during init
    u0 = upd_cnt;
    send(27, 27'h3333333);
    chk("R6 ignored in init", 32'(got), 32'(SAFE));
    chk("R6 no strobe in init", upd_cnt - u0, 0);
    @(negedge clk); init_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 safe after release", 32'(got), 32'(SAFE));
    u0 = upd_cnt;
    send(27, 27'h4444444);
    chk("R6 accepted after release", 32'(got), 32'h4444444);
    chk("R6 strobe after release", upd_cnt - u0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule